// File: doc/BRIEF.md
# Tagged Content-Addressable Search Array

This block holds a small set of 64-bit words. Each word carries two tag bits, Skip and Empty. A single compare strobe checks a 64-bit comparand against every word at once. A word takes part only when its tags satisfy the condition of that compare:

- An automatic compare accepts only valid words, where both tags are 0.
- A forced compare accepts only words whose tag pair equals a supplied code.

An optional mask removes chosen bit positions from the compare. The outcome is packed into a 32-bit status word. It holds active-low Match, Multiple-Match and Full flags, the tag pair of the word most recently read, and the index of the lowest-addressed matching word.

Word traffic travels over one access channel with valid/ready. One transfer is accepted on each edge where `acc_valid` and `acc_ready` are both high. The available operations are:

- Write a word as valid.
- Write a word with its Skip tag set.
- Invalidate a word.
- Read a word.

A read returns its data on a response channel with its own valid/ready. The response stays registered until the consumer takes it. While a response is waiting and `rd_ready` is low, `acc_ready` is low, so no new access of any kind is accepted. The compare strobe and the status output are plain pins and are never stalled.

Top module: `cam_search_array`

## Requirements
- R1: After reset every word has Skip=0 and Empty=1, masking has no effect, and `status` reads 32'hFFFF_FFFF.
- R2: An accepted access with `acc_op` 0 stores `acc_wdata` with Skip=0 and Empty=0. With `acc_op` 3 it stores the data with Skip=1 and Empty=0. With `acc_op` 2 it sets Empty=1 and Skip=0 and keeps the data.
- R3: A compare with `cmp_forced`=0 can hit only words whose Skip and Empty tags are both 0.
- R4: A compare with `cmp_forced`=1 can hit only words whose pair {Skip,Empty} equals `cmp_code` (bit 1 is Skip, bit 0 is Empty).
- R5: When `mask_en` is 1, a bit position whose `mask` bit is 1 is left out of the compare. When `mask_en` is 0, all 64 bits take part.
- R6: `status[0]` is registered one clock after `cmp_strobe`. It is 0 when at least one word hit and 1 otherwise. Without a strobe, bits 30, 27:1 and 0 keep their value.
- R7: `status[30]` is 0 after a compare in which two or more words hit, and 1 otherwise.
- R8: `status[27:1]` holds the lowest hitting word index, zero-extended, after a compare with a hit. It holds all ones after a compare with no hit.
- R9: `status[31]` is 0 exactly when no word has Empty=1. It follows the tags as they stand after the last accepted access.
- R10: An accepted read (`acc_op` 1) presents the word on `rd_data` with `rd_valid` one clock later. It also loads `status[29:28]` with that word's {Skip,Empty}. These two bits read 11 until the first read.
- R11: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold and `acc_ready` is 0. An access offered during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted when high |
| acc_op | input | 2 | 0 write valid, 1 read, 2 invalidate, 3 write with Skip |
| acc_addr | input | 3 | Word index |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_ready | input | 1 | Read response taken when high |
| rd_data | output | 64 | Read response data |
| cmp_strobe | input | 1 | Start a compare this cycle |
| cmp_forced | input | 1 | 1 selects a forced compare by tag code |
| cmp_code | input | 2 | Tag code {Skip,Empty} for forced compares |
| comparand | input | 64 | Value searched for |
| mask_en | input | 1 | Enables the compare mask |
| mask | input | 64 | Bits set to 1 are left out of the compare |
| status | output | 32 | {Full_n, Multi_n, Skip, Empty, address[26:0], Match_n} |

## Verification
The hardest condition to reach from the ports is a compare in which several words hit and the lowest one is not word 0. Such a compare must also pass through the tag gating. Random 64-bit data almost never collides, so the bench draws both the stored words and the comparand from a pool of six byte-replicated values. It also applies masks that cover whole bytes, so multiple hits are common. Directed steps add the remaining cases: a fully populated array, words tagged Skip for forced compares, and an access that is stalled behind a read response nobody takes.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int STATUS_W     = 32;
  localparam int ADDR_FIELD_W = 27;

  typedef enum logic [1:0] {
    OP_WRITE      = 2'd0,
    OP_READ       = 2'd1,
    OP_INVAL      = 2'd2,
    OP_WRITE_SKIP = 2'd3
  } acc_op_e;
endpackage

// File: rtl/cam_word_store.sv
module cam_word_store #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_skip,
  input  logic                          inv_en,
  input  logic [AW-1:0]                 addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [WORDS-1:0][DATA_W-1:0]  word_data,
  output logic [WORDS-1:0]              skip_tag,
  output logic [WORDS-1:0]              empty_tag
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = (addr == AW'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_data[w] <= '0;
        skip_tag[w]  <= 1'b0;
        empty_tag[w] <= 1'b1;
      end else if (sel && wr_en) begin
        word_data[w] <= wdata;
        skip_tag[w]  <= wr_skip;
        empty_tag[w] <= 1'b0;
      end else if (sel && inv_en) begin
        skip_tag[w]  <= 1'b0;
        empty_tag[w] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_match_vec.sv
module cam_match_vec #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64
) (
  input  logic [WORDS-1:0][DATA_W-1:0] word_data,
  input  logic [WORDS-1:0]             skip_tag,
  input  logic [WORDS-1:0]             empty_tag,
  input  logic [DATA_W-1:0]            key,
  input  logic [DATA_W-1:0]            ignore_bits,
  input  logic                         forced,
  input  logic [1:0]                   code,
  output logic [WORDS-1:0]             hit
);
  for (genvar w = 0; w < WORDS; w++) begin : g_cmp
    logic data_eq;
    logic tag_ok;
    assign data_eq = ~|((word_data[w] ^ key) & ~ignore_bits);
    assign tag_ok  = forced ? ({skip_tag[w], empty_tag[w]} == code)
                            : (!skip_tag[w] && !empty_tag[w]);
    assign hit[w]  = data_eq && tag_ok;
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int WORDS = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] hit,
  output logic             any_hit,
  output logic             multi_hit,
  output logic [AW-1:0]    first_idx
);
  assign any_hit   = |hit;
  assign multi_hit = |(hit & (hit - WORDS'(1)));

  always_comb begin
    first_idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (hit[i]) first_idx = AW'(i);
    end
  end
endmodule

// File: rtl/cam_search_array.sv
module cam_search_array
  import cam_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic [1:0]           acc_op,
  input  logic [AW-1:0]        acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 cmp_strobe,
  input  logic                 cmp_forced,
  input  logic [1:0]           cmp_code,
  input  logic [DATA_W-1:0]    comparand,
  input  logic                 mask_en,
  input  logic [DATA_W-1:0]    mask,
  output logic [STATUS_W-1:0]  status
);
  logic                         take;
  logic                         op_wr, op_rd, op_inv;
  logic [WORDS-1:0][DATA_W-1:0] word_data;
  logic [WORDS-1:0]             skip_tag, empty_tag, hit;
  logic                         any_hit, multi_hit;
  logic [AW-1:0]                first_idx;
  logic                         match_n_q, multi_n_q;
  logic [ADDR_FIELD_W-1:0]      addr_q;
  logic [1:0]                   last_tag_q;

  assign acc_ready = !rd_valid || rd_ready;
  assign take      = acc_valid && acc_ready;
  assign op_wr     = take && (acc_op == OP_WRITE || acc_op == OP_WRITE_SKIP);
  assign op_rd     = take && (acc_op == OP_READ);
  assign op_inv    = take && (acc_op == OP_INVAL);

  cam_word_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (op_wr),
    .wr_skip   (acc_op == OP_WRITE_SKIP),
    .inv_en    (op_inv),
    .addr      (acc_addr),
    .wdata     (acc_wdata),
    .word_data (word_data),
    .skip_tag  (skip_tag),
    .empty_tag (empty_tag)
  );

  cam_match_vec #(.WORDS(WORDS), .DATA_W(DATA_W)) u_match (
    .word_data   (word_data),
    .skip_tag    (skip_tag),
    .empty_tag   (empty_tag),
    .key         (comparand),
    .ignore_bits (mask_en ? mask : '0),
    .forced      (cmp_forced),
    .code        (cmp_code),
    .hit         (hit)
  );

  cam_prio_enc #(.WORDS(WORDS)) u_prio (
    .hit       (hit),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .first_idx (first_idx)
  );

  // compare result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_n_q <= 1'b1;
      multi_n_q <= 1'b1;
      addr_q    <= '1;
    end else if (cmp_strobe) begin
      match_n_q <= !any_hit;
      multi_n_q <= !multi_hit;
      addr_q    <= any_hit ? ADDR_FIELD_W'(first_idx) : '1;
    end
  end

  // read response channel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      last_tag_q <= 2'b11;
    end else if (op_rd) begin
      rd_valid   <= 1'b1;
      rd_data    <= word_data[acc_addr];
      last_tag_q <= {skip_tag[acc_addr], empty_tag[acc_addr]};
    end else if (rd_ready) begin
      rd_valid   <= 1'b0;
    end
  end

  assign status = {(|empty_tag), multi_n_q, last_tag_q, addr_q, match_n_q};
endmodule

// File: rtl/cam_search_array_chk.sv
module cam_search_array_chk #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [1:0]        acc_op,
  input logic [AW-1:0]     acc_addr,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              cmp_strobe,
  input logic [31:0]       status
);
  // R8
  no_hit_addr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (status[27:1] == '1));
  // R8
  hit_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> (status[27:1] < WORDS));
  // R7
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[30] |-> !status[0]);
  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_strobe |=> $stable(status[0]) && $stable(status[30]) && $stable(status[27:1]));
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data));
  // R11
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !acc_ready);
  // R10
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_op == 2'd1) |=> rd_valid);
endmodule

bind cam_search_array cam_search_array_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_op     (acc_op),
  .acc_addr   (acc_addr),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .cmp_strobe (cmp_strobe),
  .status     (status)
);

// File: tb/tb_cam_search_array.sv
module tb_cam_search_array;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [1:0]  acc_op = '0;
  logic [2:0]  acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [63:0] rd_data;
  logic        cmp_strobe = 1'b0;
  logic        cmp_forced = 1'b0;
  logic [1:0]  cmp_code = '0;
  logic [63:0] comparand = '0;
  logic        mask_en = 1'b0;
  logic [63:0] mask = '0;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_data [W];
  logic        m_skip [W];
  logic        m_empty[W];
  logic [1:0]  m_last;
  logic [31:0] m_res;   // bits 30, 27:1, 0 of the last compare

  always #10 clk = ~clk;

  cam_search_array dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic full_n();
    logic f = 0;
    for (int i = 0; i < W; i++) f |= m_empty[i];
    return f;
  endfunction

  function automatic logic [31:0] exp_status();
    return {full_n(), m_res[30], m_last, m_res[27:1], m_res[0]};
  endfunction

  function automatic logic [31:0] ref_compare(bit forced, logic [1:0] code,
                                              logic [63:0] key, bit men, logic [63:0] mk);
    int n = 0;
    int first = -1;
    logic [31:0] r;
    for (int i = 0; i < W; i++) begin
      bit tag_ok = forced ? ({m_skip[i], m_empty[i]} == code) : (!m_skip[i] && !m_empty[i]);
      logic [63:0] ign = men ? mk : 64'd0;
      if (tag_ok && (((m_data[i] ^ key) & ~ign) == 64'd0)) begin
        n++;
        if (first < 0) first = i;
      end
    end
    r = '0;
    r[0]    = (n == 0);
    r[30]   = (n < 2);
    r[27:1] = (n == 0) ? '1 : 27'(first);
    return r;
  endfunction

  task automatic access(logic [1:0] op, int a, logic [63:0] d);
    @(negedge clk);
    acc_valid = 1; acc_op = op; acc_addr = 3'(a); acc_wdata = d;
    @(negedge clk);
    acc_valid = 0;
    case (op)
      2'd0, 2'd3: begin m_data[a] = d; m_skip[a] = (op == 2'd3); m_empty[a] = 0; end
      2'd2: begin m_skip[a] = 0; m_empty[a] = 1; end
      default: begin
        m_last = {m_skip[a], m_empty[a]};
        check("R10 rd_valid", 64'(rd_valid), 64'd1);
        check("R10 rd_data", rd_data, m_data[a]);
      end
    endcase
    check("R9/R10 status", 64'(status), 64'(exp_status()));
  endtask

  task automatic compare(string req, bit forced, logic [1:0] code,
                         logic [63:0] key, bit men, logic [63:0] mk);
    @(negedge clk);
    cmp_strobe = 1; cmp_forced = forced; cmp_code = code;
    comparand = key; mask_en = men; mask = mk;
    m_res = ref_compare(forced, code, key, men, mk);
    @(negedge clk);
    cmp_strobe = 0;
    check(req, 64'(status), 64'(exp_status()));
  endtask

  function automatic logic [63:0] pool();
    return 64'($urandom_range(0, 5)) * 64'h0101_0101_0101_0101;
  endfunction

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < W; i++) begin m_data[i] = '0; m_skip[i] = 0; m_empty[i] = 1; end
    m_last = 2'b11;
    m_res = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 64'(status), 64'hFFFF_FFFF);
    compare("R1/R3 empty array auto", 0, 2'b00, 64'd0, 0, 64'd0);
    compare("R1/R4 forced on empty code", 1, 2'b01, 64'd0, 0, 64'd0);
    // R2 R3 R7 R8: two equal words, lowest index reported
    access(2'd0, 5, 64'h1111);
    access(2'd0, 2, 64'h1111);
    compare("R3/R7/R8 two hits", 0, 2'b00, 64'h1111, 0, 64'd0);
    // R2 skip write excluded from automatic, caught by forced
    access(2'd3, 1, 64'h1111);
    compare("R3 skip excluded", 0, 2'b00, 64'h1111, 0, 64'd0);
    compare("R4 forced skip code", 1, 2'b10, 64'h1111, 0, 64'd0);
    // R5 mask
    compare("R5 unmasked miss", 0, 2'b00, 64'h1177, 0, 64'hFF);
    compare("R5 masked hit", 0, 2'b00, 64'h1177, 1, 64'hFF);
    // R2 invalidate keeps data; forced empty code finds it
    access(2'd2, 2, 64'd0);
    compare("R2/R4 invalidated word", 1, 2'b01, 64'h1111, 0, 64'd0);
    access(2'd1, 2, 64'd0);
    // R9 fill array
    for (int i = 0; i < W; i++) access(2'd0, i, 64'(i) << 8);
    check("R9 full low", 64'(status[31]), 64'd0);
    compare("R8 last index", 0, 2'b00, 64'h0700, 0, 64'd0);
    access(2'd2, 6, 64'd0);
    check("R9 full released", 64'(status[31]), 64'd1);
    // R11 back-pressure
    rd_ready = 0;
    access(2'd1, 3, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      acc_valid = 1; acc_op = 2'd0; acc_addr = 3'd3; acc_wdata = 64'hDEAD;
      check("R11 ready low", 64'(acc_ready), 64'd0);
      check("R11 rd_valid held", 64'(rd_valid), 64'd1);
      check("R11 rd_data held", rd_data, m_data[3]);
    end
    @(negedge clk);
    acc_valid = 0;
    rd_ready = 1;
    @(negedge clk);
    check("R11 drained", 64'(rd_valid), 64'd0);
    access(2'd1, 3, 64'd0);
    check("R11 stalled write ignored", rd_data, 64'h0300);
    // R6 hold without strobe
    repeat (4) @(negedge clk);
    check("R6 hold", 64'(status), 64'(exp_status()));
    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 5) begin
        logic [1:0] op = 2'($urandom_range(0, 3));
        access(op, $urandom_range(0, W - 1), pool());
      end else begin
        logic [63:0] mk = ($urandom_range(0, 1) != 0) ? 64'h00FF_0000_0000_FF00 : 64'd0;
        compare("R3-R8 random compare", $urandom_range(0, 1) != 0, 2'($urandom_range(0, 3)),
                pool(), $urandom_range(0, 1) != 0, mk);
      end
    end
    finish_run();
  end
endmodule